// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the boundary-test port of a synchronous memory device. A four-wire serial port (test clock, mode select, serial data in, serial data out) walks a sixteen-state controller. That controller captures, shifts and updates a 3-bit instruction register and one of three data paths: a 1-bit pass-through stage, a 32-bit identification word, or a boundary register. The boundary register snapshots a parallel sample of the device pins. Its length is a parameter, 70 cells by default.

The active instruction selects the data path. It also decides whether the memory data pins are forced to high impedance while they are sampled. No instruction drives a value out of the boundary register, so the port only observes pins. No dedicated test reset pin exists. The controller reaches its reset state through the power-on reset input or through five test clocks with the mode select held high. The serial output changes only on the falling test clock edge and is qualified by an enable output that is high only while a register is being shifted.

Top module: `mem_tap`

## Requirements
- R1: While `por_n` is low, and right after it is released, the controller is in Test-Logic-Reset, the active instruction is 001 (identify), `tdo_en` is 0 and `data_hiz` is 0. A data shift from Run-Test/Idle then returns the identification word.
- R2: Five rising test clock edges with `tms` = 1 bring the controller to Test-Logic-Reset from any state. The instruction becomes 001 on the next rising edge taken in that state.
- R3: Capture-IR loads 001 into the instruction shift stage. Shift-IR moves `tdi` in at bit 2 and presents bit 0 first on `tdo`. Update-IR copies the shift stage to the active instruction.
- R4: Instruction decode is as follows. Codes 000 and 010 select the boundary register and set `data_hiz` = 1. Code 100 selects the boundary register with `data_hiz` = 0. Code 001 selects the identification word. Codes 011, 101, 110 and 111 select the 1-bit pass-through. The active instruction changes only on edges taken in Update-IR or Test-Logic-Reset.
- R5: The identification word is {revision[31:28] = 0000, configuration[27:18] = parameter (default 0011100100), vendor[17:12] = parameter (default 000000), manufacturer[11:1] = 00001001110, bit 0 = 1}, which is 32'h0390009D by default. It is loaded at Capture-DR and shifted out bit 0 first, with `tdi` entering at bit 31.
- R6: The pass-through stage is cleared to 0 at Capture-DR and delays `tdi` by one shift.
- R7: The boundary register loads `smp_i` at Capture-DR and shifts out bit 0 first, with `tdi` entering at the top cell, bit BSR_LEN-1.
- R8: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR, and `tdo` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial data in, sampled on the rising edge of `tck` |
| smp_i | input | BSR_LEN | Parallel pin sample captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge of `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data; low means the pin floats |
| data_hiz | output | 1 | Request to place the memory data pins in high impedance |

## Verification
The controller state and every shift register move on the rising edge of `tck`. The output register moves on the following falling edge, so after a shift the bench reads `tdo` one half-period later, with the new bit in place and before the next rising edge. The first bit of a capture appears at the falling edge right after the edge that enters Shift-DR or Shift-IR. A separate check confirms that `tdo` still holds the old bit just after the rising edge. `data_hiz` follows the active instruction, which is updated on the edge leaving Update-IR. The bench therefore reads it only after the walk back to Run-Test/Idle. After a mode-select reset, the instruction is read after the one extra edge taken in Test-Logic-Reset.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
  localparam logic [IR_W-1:0] IR_CAP_VAL = 3'b001;
  localparam logic [10:0]     MFG_CODE   = 11'b00001001110;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
  } tap_st_e;

  typedef enum logic [1:0] {PATH_BSR, PATH_ID, PATH_BYP} dr_path_e;

  function automatic tap_st_e tap_next(tap_st_e s, logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: return m ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: return m ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_SHF: return m ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_EX1: return m ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: return m ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: return m ? ST_DR_UPD : ST_DR_SHF;
      ST_DR_UPD: return m ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: return m ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: return m ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_SHF: return m ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_EX1: return m ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: return m ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: return m ? ST_IR_UPD : ST_IR_SHF;
      ST_IR_UPD: return m ? ST_DR_SEL : ST_IDLE;
      default:   return ST_RESET;
    endcase
  endfunction

  function automatic dr_path_e ir_path(logic [IR_W-1:0] op);
    case (op)
      3'b000, 3'b010, 3'b100: return PATH_BSR;
      3'b001:                 return PATH_ID;
      default:                return PATH_BYP;
    endcase
  endfunction

  function automatic logic ir_hiz(logic [IR_W-1:0] op);
    return (op == 3'b000) || (op == 3'b010);
  endfunction

  function automatic logic [ID_W-1:0] id_word(logic [3:0] rev, logic [9:0] cfg,
                                              logic [5:0] vnd);
    return {rev, cfg, vnd, MFG_CODE, 1'b1};
  endfunction

endpackage

// File: rtl/mtap_fsm.sv
module mtap_fsm
  import mtap_pkg::*;
(
  input  logic    tck,
  input  logic    por_n,
  input  logic    tms,
  output tap_st_e st
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) st <= ST_RESET;
    else        st <= tap_next(st, tms);
  end

endmodule

// File: rtl/mtap_ireg.sv
module mtap_ireg
  import mtap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_st_e         st,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sh
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_q  <= OP_IDENT;
      ir_sh <= IR_CAP_VAL;
    end else begin
      case (st)
        ST_RESET:  ir_q  <= OP_IDENT;
        ST_IR_CAP: ir_sh <= IR_CAP_VAL;
        ST_IR_SHF: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_IR_UPD: ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mtap_dreg.sv
module mtap_dreg
  import mtap_pkg::*;
#(
  parameter int          BSR_LEN = 70,
  parameter logic [31:0] ID_VAL  = 32'h0
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  tap_st_e            st,
  input  dr_path_e           path,
  input  logic [BSR_LEN-1:0] smp_i,
  output logic               byp_q,
  output logic [ID_W-1:0]    id_q,
  output logic [BSR_LEN-1:0] bsr_q
);

  logic cap, shf;
  assign cap = (st == ST_DR_CAP);
  assign shf = (st == ST_DR_SHF);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                          byp_q <= 1'b0;
    else if (path == PATH_BYP && cap)    byp_q <= 1'b0;
    else if (path == PATH_BYP && shf)    byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                         id_q <= ID_VAL;
    else if (path == PATH_ID && cap)    id_q <= ID_VAL;
    else if (path == PATH_ID && shf)    id_q <= {tdi, id_q[ID_W-1:1]};
  end

  logic bsr_cap, bsr_shf;
  assign bsr_cap = cap && (path == PATH_BSR);
  assign bsr_shf = shf && (path == PATH_BSR);

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic nxt, cell_q;
    if (i == BSR_LEN - 1) begin : g_top
      assign nxt = tdi;
    end else begin : g_mid
      assign nxt = bsr_q[i+1];
    end
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)       cell_q <= 1'b0;
      else if (bsr_cap) cell_q <= smp_i[i];
      else if (bsr_shf) cell_q <= nxt;
    end
    assign bsr_q[i] = cell_q;
  end

endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import mtap_pkg::*;
#(
  parameter int          BSR_LEN = 70,
  parameter logic [3:0]  ID_REV  = 4'b0000,
  parameter logic [9:0]  ID_CFG  = 10'b0011100100,
  parameter logic [5:0]  ID_VND  = 6'b000000
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] smp_i,
  output logic               tdo,
  output logic               tdo_en,
  output logic               data_hiz
);

  localparam logic [ID_W-1:0] ID_WORD = id_word(ID_REV, ID_CFG, ID_VND);

  tap_st_e            st;
  logic [IR_W-1:0]    ir_q, ir_sh;
  dr_path_e           path;
  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;
  logic               shift_bit, in_shift;

  mtap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .st(st));

  mtap_ireg u_ireg (.tck(tck), .por_n(por_n), .tdi(tdi), .st(st),
                    .ir_q(ir_q), .ir_sh(ir_sh));

  assign path     = ir_path(ir_q);
  assign data_hiz = ir_hiz(ir_q);

  mtap_dreg #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_WORD)) u_dreg (
    .tck(tck), .por_n(por_n), .tdi(tdi), .st(st), .path(path),
    .smp_i(smp_i), .byp_q(byp_q), .id_q(id_q), .bsr_q(bsr_q)
  );

  assign in_shift = (st == ST_DR_SHF) || (st == ST_IR_SHF);

  always_comb begin
    shift_bit = 1'b0;
    if (st == ST_IR_SHF) shift_bit = ir_sh[0];
    else if (st == ST_DR_SHF) begin
      case (path)
        PATH_BSR: shift_bit = bsr_q[0];
        PATH_ID:  shift_bit = id_q[0];
        default:  shift_bit = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= shift_bit;
      tdo_en <= in_shift;
    end
  end

endmodule

// File: rtl/mtap_chk.sv
module mtap_chk
  import mtap_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h0
) (
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input tap_st_e         st,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sh,
  input dr_path_e        path,
  input logic            byp_q,
  input logic [ID_W-1:0] id_q,
  input logic            tdo_en
);

  logic [2:0] ones;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)      ones <= 3'd0;
    else if (!tms)   ones <= 3'd0;
    else if (ones != 3'd7) ones <= ones + 3'd1;
  end

  p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!por_n)
    (ones >= 3'd5) |-> (st == ST_RESET));

  p_reset_sets_ident_r2: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_RESET) |=> (ir_q == 3'b001));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_IR_CAP) |=> (ir_sh == 3'b001));

  p_ir_hold_r4: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_q) |-> ($past(st) == ST_IR_UPD || $past(st) == ST_RESET));

  p_id_capture_r5: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_DR_CAP && path == PATH_ID) |=> (id_q == ID_WORD));

  p_bypass_clear_r6: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_DR_CAP && path == PATH_BYP) |=> (byp_q == 1'b0));

  p_tdo_en_window_r8: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en == (st == ST_DR_SHF || st == ST_IR_SHF));

endmodule

bind mem_tap mtap_chk #(.ID_WORD(ID_WORD)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .st(st), .ir_q(ir_q), .ir_sh(ir_sh),
  .path(path), .byp_q(byp_q), .id_q(id_q), .tdo_en(tdo_en)
);

// File: tb/mem_tap_bench.sv
module mem_tap_bench;

  localparam int BL = 70;
  localparam logic [31:0] EXP_ID = 32'h0390_009D;
  localparam logic [BL-1:0] PAT = {6'h2D, 64'hA5C3_1F07_9E64_B28D};
  // {code[2:0], kind[1:0] (0 boundary, 1 id, 2 pass-through), hiz}
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 2'd0, 1'b1}, {3'b001, 2'd1, 1'b0}, {3'b010, 2'd0, 1'b1},
    {3'b011, 2'd2, 1'b0}, {3'b100, 2'd0, 1'b0}, {3'b101, 2'd2, 1'b0},
    {3'b110, 2'd2, 1'b0}, {3'b111, 2'd2, 1'b0}};

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic [BL-1:0] smp = '0;
  logic tdo, tdo_en, data_hiz;
  int nchk = 0, nfail = 0;

  mem_tap #(.BSR_LEN(BL)) u_mem_tap (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
    .smp_i(smp), .tdo(tdo), .tdo_en(tdo_en), .data_hiz(data_hiz));

  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din,
                          output logic [127:0] dout, output bit en_ok);
    dout = '0; en_ok = 1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (!tdo_en) en_ok = 0;
      tick(i == n - 1, din[i]);
    end
    if (tdo_en) en_ok = 0;
    tick(1, 0); tick(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [127:0] dout, din, exp;
    logic [2:0] cap;
    bit en_ok;
    smp = PAT;
    #35;
    chk(tdo_en == 0, "R1 tdo_en in reset", 128'(tdo_en), 0);
    chk(data_hiz == 0, "R1 data_hiz in reset", 128'(data_hiz), 0);
    por_n = 1'b1;
    @(negedge tck); #1;
    tick(0, 0);
    shift_dr(32, '0, dout, en_ok);
    chk(dout[31:0] == EXP_ID, "R1 identify after power-up", dout, 128'(EXP_ID));

    // table walk over all instruction codes
    for (int k = 0; k < 8; k++) begin
      logic [2:0] op;
      op = VEC[k][5:3];
      load_ir(op, cap);
      chk(cap == 3'b001, "R3 capture-ir pattern", 128'(cap), 128'(3'b001));
      chk(data_hiz == VEC[k][0], "R4 hiz for code", 128'(data_hiz), 128'(VEC[k][0]));
      din = 128'h5A3C_96E1_0F87_D2B4_C3A5_1E69_7B2D_4F1C;
      exp = '0;
      case (VEC[k][2:1])
        2'd0: begin
          shift_dr(BL + 4, din, dout, en_ok);
          exp[BL-1:0] = PAT; exp[BL+3 -: 4] = din[3:0];
          chk(dout == exp, "R7 boundary capture and shift", dout, exp);
        end
        2'd1: begin
          shift_dr(36, din, dout, en_ok);
          exp[31:0] = EXP_ID; exp[35:32] = din[3:0];
          chk(dout == exp, "R5 identification word", dout, exp);
        end
        default: begin
          shift_dr(9, din, dout, en_ok);
          exp[8:0] = {din[7:0], 1'b0};
          chk(dout == exp, "R6 pass-through delay", dout, exp);
        end
      endcase
      chk(en_ok, "R8 tdo_en shift window", 128'(en_ok), 1);
    end

    // R2: mode-select reset from the middle of a data shift
    load_ir(3'b010, cap);
    chk(data_hiz == 1, "R2 precondition hiz", 128'(data_hiz), 1);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1); tick(0, 0);
    for (int j = 0; j < 5; j++) tick(1, 0);
    chk(tdo_en == 0, "R2 output idle after reset walk", 128'(tdo_en), 0);
    tick(0, 0);
    chk(data_hiz == 0, "R2 instruction back to identify", 128'(data_hiz), 0);
    shift_dr(32, '0, dout, en_ok);
    chk(dout[31:0] == EXP_ID, "R2 identify after tms reset", dout, 128'(EXP_ID));

    // R2 from Pause-IR
    tick(1, 0); tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int j = 0; j < 5; j++) tick(1, 0);
    tick(0, 0);
    shift_dr(32, '0, dout, en_ok);
    chk(dout[31:0] == EXP_ID, "R2 reset from pause-ir", dout, 128'(EXP_ID));

    // R8: tdo moves on the falling edge only
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk(tdo == 1'b1, "R8 first id bit", 128'(tdo), 1);
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    chk(tdo == 1'b1, "R8 tdo held past rising edge", 128'(tdo), 1);
    @(negedge tck); #1;
    chk(tdo == 1'b0, "R8 tdo updated at falling edge", 128'(tdo), 0);
    for (int j = 0; j < 5; j++) tick(1, 0);
    chk(tdo == 1'b0 && tdo_en == 0, "R8 tdo quiet outside shift",
        128'({tdo, tdo_en}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule